// File: doc/BRIEF.md
# Serial Stream Receive Deserializer with Byte Reversal

This block is the receive half of a memory-card controller's data path when the card streams data to the controller. It watches a one-bit serial data line, sampled on the rising edge of the feedback clock `clk`. Once software arms a transfer, the block waits for the start bit. It throws that bit away, then gathers the data bits that follow, most significant bit first, into a 32-bit shift register. Each complete word is pushed into a small receive FIFO with its byte order reversed. A trailing partial word is stored right-justified, with zero in its unused upper bytes.

The transfer length is given in bytes. A data timer limits how long the block waits for the start bit. When the transfer ends, one of two sticky flags reports the result: done or timeout. A third sticky flag records any word that was dropped because the FIFO was full. Software arms a transfer with a one-cycle `start_i` pulse, then drains the FIFO through a show-ahead read port.

Top module: `rxdes_top`

## Requirements
- R1: After a synchronous reset the FIFO is empty (`empty_o`=1, `level_o`=0) and `busy_o`, `done_o`, `timeout_o` and `overrun_o` are all 0.
- R2: When the block is idle and `start_i` is high with `len_i` nonzero, the block becomes busy and waits for the first 0 sample on the idle-high `sdat_i` line. That sample is the start bit. It is discarded and is neither counted nor stored, and the bits after it are data.
- R3: Data bits arrive most significant bit first. In every stored word, the k-th byte received within that word (k = 0 to 3) sits in bits [8k+7:8k], so the first byte received goes to bits [7:0].
- R4: `len_i` is a byte count, and a transfer of n bytes stores ceil(n/4) words. Word i holds bytes 4i to 4i+3.
- R5: A final word with fewer than 4 bytes is right-justified: its bytes fill the low byte lanes in receive order, and the unused upper lanes are 0.
- R6: When the last programmed byte has been sampled, the block sets `done_o`, clears `busy_o` on the same edge and stores the last word on that edge. A start with `len_i`=0 sets `done_o` on the start edge, stays idle and stores nothing. `done_o` and `timeout_o` are never both set.
- R7: While waiting for the start bit, the timer is loaded with `tmo_i`, and a value of 0 is treated as 1. If N consecutive samples are high without a start bit, `timeout_o` is set on the N-th sample edge, the block returns to idle, and nothing is written to the FIFO.
- R8: A word completed while the FIFO holds `FIFO_DEPTH` words is dropped, even if a read happens in the same cycle. The drop sets the sticky `overrun_o`, and reception continues to the end of the transfer.
- R9: `rd_data_o` shows the oldest stored word whenever `empty_o` is 0. `rd_en_i` removes that word. `rd_en_i` while the FIFO is empty has no effect.
- R10: An accepted start clears `done_o`, `timeout_o` and `overrun_o`, and the FIFO keeps its contents.
- R11: `start_i` and `len_i` are ignored while the block is busy, so the transfer in progress keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Feedback clock, rising edge samples the line |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Arms a receive transfer when idle |
| len_i | input | LEN_W | Transfer length in bytes |
| tmo_i | input | TMR_W | Start-bit wait limit in samples (0 acts as 1) |
| sdat_i | input | 1 | Serial data line, idle high |
| rd_en_i | input | 1 | Pops the oldest FIFO word |
| rd_data_o | output | 32 | Oldest FIFO word (show-ahead) |
| empty_o | output | 1 | FIFO holds no word |
| level_o | output | clog2(FIFO_DEPTH)+1 | Number of words held |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky: all bytes received |
| timeout_o | output | 1 | Sticky: no start bit within the limit |
| overrun_o | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
Every length from 0 to 16 bytes is swept with several seeds. The sweep covers full words, every size of trailing partial word, and the zero-length case. Byte values change with their index, so a wrong lane order, a swap of bit order or a start bit counted as data each yields a different value. The gap of idle-high samples before the start bit is varied, including one sample short of the timer limit, and timeouts are tried with limits of 0 and 4 to separate an off-by-one from correct expiry. A 20-byte transfer into an undrained FIFO, a start pulse held during reception with a different length, and reads on an empty FIFO check the drop, ignore and no-effect cases.

// File: rtl/rxdes_pkg.sv
package rxdes_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTES_W = WORD_W / 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_WAIT  = 2'd1,
        RX_SHIFT = 2'd2
    } rx_state_e;

    typedef struct packed {
        logic              valid;
        logic [2:0]        nbytes;
        logic [WORD_W-1:0] data;
    } word_wr_t;

    // Move the newest n bytes of the shift register to the top lanes.
    function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] v,
                                                     input logic [2:0] n);
        logic [WORD_W-1:0] r;
        case (n)
            3'd1:    r = {v[7:0], 24'h0};
            3'd2:    r = {v[15:0], 16'h0};
            3'd3:    r = {v[23:0], 8'h0};
            default: r = v;
        endcase
        return r;
    endfunction

    // Reverse the byte lanes of a word.
    function automatic logic [WORD_W-1:0] lane_reverse(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int k = 0; k < BYTES_W; k++) begin
            r[8*k +: 8] = v[8*(BYTES_W-1-k) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/rxdes_timer.sv
module rxdes_timer
    import rxdes_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    input  logic             tick_i,
    output logic             expired_o
);

    logic [TMR_W-1:0] cnt_q;

    assign expired_o = tick_i && (cnt_q <= TMR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (load_val_i == '0) ? TMR_W'(1) : load_val_i;
        end else if (tick_i && cnt_q > TMR_W'(1)) begin
            cnt_q <= cnt_q - TMR_W'(1);
        end
    end

    AST_TMR_LOADED_NONZERO: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q != '0)); // R7

endmodule

// File: rtl/rxdes_frame.sv
module rxdes_frame
    import rxdes_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             sdat_i,
    input  logic             tmr_exp_i,
    output logic             start_acc_o,
    output logic             tmr_load_o,
    output logic             tmr_tick_o,
    output word_wr_t         wr_o,
    output logic             end_ok_o,
    output logic             end_tmo_o,
    output logic             busy_o
);

    rx_state_e         state_q;
    logic [WORD_W-1:0] sr_q;
    logic [4:0]        bit_cnt_q;
    logic [LEN_W-1:0]  left_q;

    logic [WORD_W-1:0] sr_nx;
    logic              in_shift;
    logic              byte_end;
    logic              last_byte;
    logic              word_full;
    logic [2:0]        word_bytes;

    always_comb begin
        in_shift    = (state_q == RX_SHIFT);
        sr_nx       = {sr_q[WORD_W-2:0], sdat_i};
        byte_end    = in_shift && (bit_cnt_q[2:0] == 3'd7);
        last_byte   = byte_end && (left_q == LEN_W'(1));
        word_full   = byte_end && (bit_cnt_q[4:3] == 2'd3);
        word_bytes  = {1'b0, bit_cnt_q[4:3]} + 3'd1;

        start_acc_o = (state_q == RX_IDLE) && start_i;
        tmr_load_o  = start_acc_o;
        tmr_tick_o  = (state_q == RX_WAIT) && sdat_i;
        end_tmo_o   = tmr_tick_o && tmr_exp_i;
        end_ok_o    = last_byte || (start_acc_o && len_i == '0);
        busy_o      = (state_q != RX_IDLE);

        wr_o.valid  = last_byte || word_full;
        wr_o.nbytes = word_bytes;
        wr_o.data   = lane_reverse(left_align(sr_nx, word_bytes));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RX_IDLE;
            sr_q      <= '0;
            bit_cnt_q <= '0;
            left_q    <= '0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (start_i && len_i != '0) begin
                        state_q <= RX_WAIT;
                        left_q  <= len_i;
                    end
                end
                RX_WAIT: begin
                    if (!sdat_i) begin
                        state_q   <= RX_SHIFT;
                        bit_cnt_q <= '0;
                    end else if (tmr_exp_i) begin
                        state_q <= RX_IDLE;
                    end
                end
                RX_SHIFT: begin
                    sr_q      <= sr_nx;
                    bit_cnt_q <= bit_cnt_q + 5'd1;
                    if (byte_end) left_q <= left_q - LEN_W'(1);
                    if (last_byte) state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    AST_START_BIT_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_WAIT && !sdat_i) |=> (state_q == RX_SHIFT && bit_cnt_q == 5'd0)); // R2

    AST_NO_WRITE_OUTSIDE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (state_q != RX_SHIFT) |-> !wr_o.valid); // R7

    AST_PARTIAL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr_o.valid && wr_o.nbytes == 3'd1) |-> (wr_o.data[31:8] == 24'h0)); // R5

    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (state_q == RX_SHIFT && !byte_end) |=> $stable(left_q)); // R11

endmodule

// File: rtl/rxdes_fifo.sv
module rxdes_fifo
    import rxdes_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  word_wr_t                   wr_i,
    input  logic                       rd_en_i,
    output logic [WORD_W-1:0]          rd_data_o,
    output logic                       empty_o,
    output logic                       full_o,
    output logic [$clog2(DEPTH):0]     level_o
);

    localparam int AW = $clog2(DEPTH);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [AW:0]       wptr_q;
    logic [AW:0]       rptr_q;
    logic              push;
    logic              pop;

    always_comb begin
        level_o   = wptr_q - rptr_q;
        empty_o   = (level_o == '0);
        full_o    = (level_o == (AW+1)'(DEPTH));
        push      = wr_i.valid && !full_o;
        pop       = rd_en_i && !empty_o;
        rd_data_o = mem_q[rptr_q[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + (AW+1)'(1);
            if (pop)  rptr_q <= rptr_q + (AW+1)'(1);
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_q[g] <= '0;
                end else if (push && wptr_q[AW-1:0] == AW'(g)) begin
                    mem_q[g] <= wr_i.data;
                end
            end
        end
    endgenerate

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level_o <= (AW+1)'(DEPTH)); // R8

    AST_FULL_DROPS_WORD: assert property (@(posedge clk) disable iff (rst)
        (wr_i.valid && full_o) |=> $stable(wptr_q)); // R8

    AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && empty_o && !wr_i.valid) |=> (level_o == '0)); // R9

endmodule

// File: rtl/rxdes_top.sv
module rxdes_top
    import rxdes_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int TMR_W      = 16,
    parameter int FIFO_DEPTH = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [TMR_W-1:0]  tmo_i,
    input  logic              sdat_i,
    input  logic              rd_en_i,
    output logic [31:0]       rd_data_o,
    output logic              empty_o,
    output logic [LVL_W-1:0]  level_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              overrun_o
);

    logic     start_acc;
    logic     tmr_load;
    logic     tmr_tick;
    logic     tmr_exp;
    logic     end_ok;
    logic     end_tmo;
    logic     fifo_full;
    word_wr_t wr;

    logic done_q;
    logic tmo_q;
    logic ovr_q;

    rxdes_timer #(.TMR_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmo_i),
        .tick_i     (tmr_tick),
        .expired_o  (tmr_exp)
    );

    rxdes_frame #(.LEN_W(LEN_W)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .len_i       (len_i),
        .sdat_i      (sdat_i),
        .tmr_exp_i   (tmr_exp),
        .start_acc_o (start_acc),
        .tmr_load_o  (tmr_load),
        .tmr_tick_o  (tmr_tick),
        .wr_o        (wr),
        .end_ok_o    (end_ok),
        .end_tmo_o   (end_tmo),
        .busy_o      (busy_o)
    );

    rxdes_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .empty_o   (empty_o),
        .full_o    (fifo_full),
        .level_o   (level_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (start_acc) begin
                done_q <= 1'b0;
                tmo_q  <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (end_ok)                done_q <= 1'b1;
            if (end_tmo)               tmo_q  <= 1'b1;
            if (wr.valid && fifo_full) ovr_q  <= 1'b1;
        end
    end

    assign done_o    = done_q;
    assign timeout_o = tmo_q;
    assign overrun_o = ovr_q;

    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_o && timeout_o)); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R6

    AST_TIMEOUT_ENDS: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_o) |-> (!busy_o && !done_o)); // R7

endmodule

// File: tb/sim_rxdes_top.sv
module sim_rxdes_top;

    localparam int LEN_W = 16;
    localparam int TMR_W = 16;
    localparam int DEPTH = 4;
    localparam int LVL_W = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic [TMR_W-1:0] tmo_i = '0;
    logic             sdat_i = 1'b1;
    logic             rd_en_i = 1'b0;
    logic [31:0]      rd_data_o;
    logic             empty_o;
    logic [LVL_W-1:0] level_o;
    logic             busy_o;
    logic             done_o;
    logic             timeout_o;
    logic             overrun_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    rxdes_top #(.LEN_W(LEN_W), .TMR_W(TMR_W), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .tmo_i(tmo_i),
        .sdat_i(sdat_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
        .empty_o(empty_o), .level_o(level_o), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o), .overrun_o(overrun_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int idx);
        return 8'((seed * 53 + idx * 29 + 7) & 255);
    endfunction

    function automatic logic [31:0] exp_word(input int seed, input int len, input int w);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            if (4 * w + k < len) r[8*k +: 8] = bval(seed, 4 * w + k);
        end
        return r;
    endfunction

    // Arm a transfer, idle for gap samples, send start bit and len bytes.
    task automatic send_frame(input int len, input int seed, input int gap,
                              input int tmo, input bit hold_start);
        @(negedge clk);
        start_i = 1'b1;
        len_i   = LEN_W'(len);
        tmo_i   = TMR_W'(tmo);
        @(negedge clk);
        start_i = 1'b0;
        if (len != 0) begin
            for (int g = 0; g < gap; g++) begin
                sdat_i = 1'b1;
                @(negedge clk);
            end
            sdat_i = 1'b0;
            @(negedge clk);
            for (int b = 0; b < len; b++) begin
                for (int i = 7; i >= 0; i--) begin
                    sdat_i = bval(seed, b)[i];
                    if (hold_start && b == 0) begin
                        start_i = 1'b1;
                        len_i   = LEN_W'(len + 5);
                    end else begin
                        start_i = 1'b0;
                        len_i   = LEN_W'(len);
                    end
                    @(negedge clk);
                end
            end
            sdat_i = 1'b1;
        end
    endtask

    task automatic drain_check(input int len, input int seed, input int nwords, input string tag);
        for (int w = 0; w < nwords; w++) begin
            chk({tag, " empty"}, 32'(empty_o), 32'd0);
            chk({tag, " word"}, rd_data_o, exp_word(seed, len, w));
            rd_en_i = 1'b1;
            @(negedge clk);
            rd_en_i = 1'b0;
        end
        chk({tag, " drained"}, 32'(level_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 empty", 32'(empty_o), 32'd1);
        chk("R1 level", 32'(level_o), 32'd0);
        chk("R1 flags", {28'd0, busy_o, done_o, timeout_o, overrun_o}, 32'd0);

        // R9 read on empty FIFO has no effect
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
        chk("R9 empty read level", 32'(level_o), 32'd0);
        chk("R9 empty read flag", 32'(empty_o), 32'd1);

        // R2 R3 R4 R5 R6 length sweep
        for (int seed = 0; seed < 3; seed++) begin
            for (int len = 0; len <= 16; len++) begin
                send_frame(len, seed, len % 3, 20, 1'b0);
                chk("R6 done", 32'(done_o), 32'd1);
                chk("R6 not busy", 32'(busy_o), 32'd0);
                chk("R6 no timeout", 32'(timeout_o), 32'd0);
                chk("R4 word count", 32'(level_o), 32'((len + 3) / 4));
                drain_check(len, seed, (len + 3) / 4, "R3 R5 sweep");
            end
        end

        // R7 gap one short of the limit still receives
        send_frame(3, 7, 3, 4, 1'b0);
        chk("R7 near limit done", 32'(done_o), 32'd1);
        chk("R7 near limit timeout", 32'(timeout_o), 32'd0);
        drain_check(3, 7, 1, "R7 near limit");

        // R7 timeout with limit 4
        @(negedge clk);
        sdat_i = 1'b1; start_i = 1'b1; len_i = 16'd4; tmo_i = 16'd4;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 done cleared", 32'(done_o), 32'd0);
        repeat (3) @(negedge clk);
        chk("R7 not yet", 32'(timeout_o), 32'd0);
        chk("R7 still busy", 32'(busy_o), 32'd1);
        @(negedge clk);
        chk("R7 timeout", 32'(timeout_o), 32'd1);
        chk("R7 idle", 32'(busy_o), 32'd0);
        chk("R7 nothing stored", 32'(level_o), 32'd0);

        // R7 limit 0 acts as 1
        start_i = 1'b1; tmo_i = 16'd0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 timeout cleared", 32'(timeout_o), 32'd0);
        @(negedge clk);
        chk("R7 zero limit", 32'(timeout_o), 32'd1);

        // R11 start held with another length during reception
        send_frame(6, 4, 1, 20, 1'b1);
        chk("R11 done", 32'(done_o), 32'd1);
        chk("R11 word count", 32'(level_o), 32'd2);
        drain_check(6, 4, 2, "R11 length kept");

        // R8 overrun: 20 bytes into a 4-word FIFO with no reads
        send_frame(20, 9, 0, 20, 1'b0);
        chk("R8 overrun", 32'(overrun_o), 32'd1);
        chk("R8 done anyway", 32'(done_o), 32'd1);
        chk("R8 level full", 32'(level_o), 32'd4);
        drain_check(20, 9, 4, "R8 kept words");

        // R10 next start clears overrun
        send_frame(1, 2, 0, 20, 1'b0);
        chk("R10 overrun cleared", 32'(overrun_o), 32'd0);
        drain_check(1, 2, 1, "R10 single byte");

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule